// File: doc/BRIEF.md
# Flash Program/Erase Command Sequencer

This block sits on the host side of an asynchronous parallel NOR-style flash device and carries out one word program or one block erase per request. A request gives the operation kind, the target address, the data word, a byte/word width choice and a flag marking a target inside the protected boot region. The sequencer issues the two write-enable-strobed bus cycles the device expects, waits out the post-write recovery gap, and polls the device status byte with output-enable low until the ready bit is set. It then pulses `done` with the captured status and the error flags.

Every bus timing minimum is given as a nanosecond parameter. It is converted to whole clock cycles by rounding up against the clock period parameter. The controller drives the data lines only during write cycles, and it leaves them undriven for at least one cycle before output-enable falls. A poll-time limit ends a stalled operation with a timeout flag. Every operation, including one that timed out, ends with a clear-status write and a return-to-read-array write before the request port is ready again. A separate unlock output is held high for the whole of an operation aimed at the boot region.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is held and after it is released, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are 1, `fl_dq_oe` is 0, `fl_unlock` is 0, `done` is 0 and `req_ready` is 1.
- R2: A program request (`req_erase`=0) produces first a write of command 0x40 and then a write of `req_data` to `req_addr`. In byte mode only bits 7:0 of the data are meaningful.
- R3: An erase request (`req_erase`=1) produces first a write of command 0x20 and then a write of command 0xD0 to `req_addr`.
- R4: Each write-enable low pulse lasts at least LO_CYC = ceil(max(tWP, tAS, tDS)/CLK_NS) cycles. The high time between back-to-back pulses is at least ceil(tWPH/CLK_NS) cycles, and low plus high is at least ceil(tWC/CLK_NS) cycles. Address and data do not change while write-enable is low.
- R5: The first output-enable fall after the second write of an operation comes at least ceil(tWB/CLK_NS) cycles after that write's rising edge.
- R6: `fl_dq_oe` is 0 in every cycle in which `fl_oe_n` is 0, and also in the cycle just before `fl_oe_n` falls.
- R7: Status is polled until bit 7 of `fl_dq_in` reads 1. `done` is then high for exactly one cycle per operation, with `done_status` equal to the status byte read in the final poll.
- R8: `done_err` is 1 when any of status bits 5 (erase failure), 4 (program failure) or 3 (low programming voltage) is set, or when a timeout occurred.
- R9: If bit 7 does not read 1 within POLL_LIMIT cycles of the start of the recovery wait, `done` is raised with `done_timeout`=1 and `done_err`=1.
- R10: After `done`, the sequencer writes command 0x50 and then command 0xFF, and only then raises `req_ready` again. An operation therefore consists of exactly four writes.
- R11: In byte mode (`req_byte`=1), `fl_byte_n` is 0 and `fl_dq_oe` is 2'b01 during writes. In word mode, `fl_byte_n` is 1, `fl_dq_oe` is 2'b11, and command writes carry 0 in bits 15:8.
- R12: For a request with `req_boot`=1, `fl_unlock` is 1 at every write-enable fall of that operation. For `req_boot`=0 it stays 0. It never falls while write-enable is low.
- R13: `req_valid` is ignored while `req_ready` is 0. The running operation keeps its address and its sequence of four writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an operation (accepted when ready) |
| req_ready | output | 1 | Idle and able to accept a request |
| req_erase | input | 1 | 1 = block erase, 0 = word program |
| req_boot | input | 1 | Target lies in the protected boot region |
| req_byte | input | 1 | 1 = 8-bit bus mode, 0 = 16-bit |
| req_addr | input | AW | Target address |
| req_data | input | 16 | Program data |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 8 | Status byte of the final poll |
| done_err | output | 1 | Device error bit or timeout |
| done_timeout | output | 1 | Poll limit expired |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_byte_n | output | 1 | Flash width select, low = 8-bit |
| fl_unlock | output | 1 | Boot region unlock |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 16 | Data driven to flash |
| fl_dq_oe | output | 2 | Per-byte data drive enable |
| fl_dq_in | input | 16 | Data read from flash |

## Verification
The in-line properties check on every cycle that the data bus is never driven while output-enable is low or in the cycle before it falls. They also check that each write-enable low pulse reaches its minimum length with address and data held, that `done` is a single-cycle pulse, that the target address cannot change while busy, and that the unlock line never drops in the middle of a write pulse. The command order and payloads, the recovery gap before the first poll, the high-time and cycle-time minimums, the error and timeout reporting, the byte/word lane enables and the closing clear/read-array writes depend on a device model answering status reads. Only the bench scenarios show these, using varied busy times, error bits, modes and a device that never becomes ready.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WLO,
    ST_WHI,
    ST_RECOV,
    ST_RDLO,
    ST_RDHI,
    ST_FIN
  } seq_state_t;

  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_CONF  = 8'hD0;
  localparam logic [7:0] CMD_CLR_STAT    = 8'h50;
  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fseq_timer.sv
module fseq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/fseq_watch.sv
module fseq_watch #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  localparam int PW = $clog2(LIMIT + 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_d;
  logic          cnt_en;
  logic          hit;

  assign hit = (cnt_q >= PW'(LIMIT));

  always_comb begin
    cnt_en = !run || !hit;
    cnt_d  = run ? (cnt_q + 1'b1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = run && hit;

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int AW         = 20,
  parameter int CLK_NS     = 10,
  parameter int T_WP_NS    = 50,
  parameter int T_WPH_NS   = 20,
  parameter int T_WC_NS    = 90,
  parameter int T_AS_NS    = 50,
  parameter int T_DS_NS    = 50,
  parameter int T_WB_NS    = 200,
  parameter int T_RD_NS    = 90,
  parameter int POLL_LIMIT = 60000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_erase,
  input  logic          req_boot,
  input  logic          req_byte,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_data,
  output logic          done,
  output logic [7:0]    done_status,
  output logic          done_err,
  output logic          done_timeout,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic          fl_byte_n,
  output logic          fl_unlock,
  output logic [AW-1:0] fl_addr,
  output logic [15:0]   fl_dq_out,
  output logic [1:0]    fl_dq_oe,
  input  logic [15:0]   fl_dq_in
);

  localparam int LO_CYC  = ns2cyc(imax(T_WP_NS, imax(T_AS_NS, T_DS_NS)), CLK_NS);
  localparam int HI_CYC  = imax(ns2cyc(T_WPH_NS, CLK_NS),
                                imax(ns2cyc(T_WC_NS, CLK_NS) - LO_CYC, 1));
  localparam int WB_CYC  = ns2cyc(T_WB_NS, CLK_NS);
  localparam int REC_CYC = imax(WB_CYC - HI_CYC, 1);
  localparam int RD_CYC  = ns2cyc(T_RD_NS, CLK_NS);
  localparam int TMAX    = imax(imax(LO_CYC, HI_CYC), imax(REC_CYC, RD_CYC));
  localparam int TW      = $clog2(TMAX + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_q    <= rst_s1_q;
    end
  end

  seq_state_t    state_q, state_d;
  logic [1:0]    idx_q, idx_d;
  logic          erase_q, boot_q, byte_q;
  logic [AW-1:0] addr_q;
  logic [15:0]   data_q;
  logic [7:0]    stat_q;
  logic          to_q;
  logic          accept;
  logic          cap_en;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;
  logic          poll_run;
  logic          poll_exp;

  fseq_timer #(.TW(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_q),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  assign poll_run = (state_q == ST_RECOV) || (state_q == ST_RDLO) || (state_q == ST_RDHI);

  fseq_watch #(.LIMIT(POLL_LIMIT)) u_watch (
    .clk     (clk),
    .rst_n   (rst_q),
    .run     (poll_run),
    .expired (poll_exp)
  );

  assign accept = (state_q == ST_IDLE) && req_valid;
  assign cap_en = (state_q == ST_RDLO) && tmr_zero;

  // next-state
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    case (state_q)
      ST_IDLE:  if (req_valid) begin state_d = ST_WLO; idx_d = 2'd0; end
      ST_WLO:   if (tmr_zero) state_d = ST_WHI;
      ST_WHI:   if (tmr_zero) begin
                  if (idx_q == 2'd1)      state_d = ST_RECOV;
                  else if (idx_q == 2'd3) state_d = ST_IDLE;
                  else begin state_d = ST_WLO; idx_d = idx_q + 2'd1; end
                end
      ST_RECOV: if (tmr_zero) state_d = ST_RDLO;
      ST_RDLO:  if (tmr_zero) state_d = (fl_dq_in[7] || poll_exp) ? ST_FIN : ST_RDHI;
      ST_RDHI:  state_d = ST_RDLO;
      ST_FIN:   begin state_d = ST_WLO; idx_d = 2'd2; end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = (state_d != state_q);
    case (state_d)
      ST_WLO:   tmr_val = TW'(LO_CYC - 1);
      ST_WHI:   tmr_val = TW'(HI_CYC - 1);
      ST_RECOV: tmr_val = TW'(REC_CYC - 1);
      ST_RDLO:  tmr_val = TW'(RD_CYC - 1);
      default:  tmr_val = '0;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q <= ST_IDLE;
      idx_q   <= 2'd0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      erase_q <= 1'b0;
      boot_q  <= 1'b0;
      byte_q  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (accept) begin
      erase_q <= req_erase;
      boot_q  <= req_boot;
      byte_q  <= req_byte;
      addr_q  <= req_addr;
      data_q  <= req_data;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      stat_q <= 8'h00;
      to_q   <= 1'b0;
    end else if (cap_en) begin
      stat_q <= fl_dq_in[7:0];
      to_q   <= !fl_dq_in[7] && poll_exp;
    end
  end

  // bus decode
  logic [7:0]  cmd_byte;
  logic        payload;
  logic        wr_phase;

  always_comb begin
    payload = 1'b0;
    case (idx_q)
      2'd0:    cmd_byte = erase_q ? CMD_ERASE_SETUP : CMD_PROG_SETUP;
      2'd1:    begin cmd_byte = CMD_ERASE_CONF; payload = !erase_q; end
      2'd2:    cmd_byte = CMD_CLR_STAT;
      default: cmd_byte = CMD_READ_ARRAY;
    endcase
  end

  assign wr_phase  = (state_q == ST_WLO) || (state_q == ST_WHI);
  assign fl_dq_out = payload ? (byte_q ? {8'h00, data_q[7:0]} : data_q) : {8'h00, cmd_byte};
  assign fl_dq_oe  = wr_phase ? (byte_q ? 2'b01 : 2'b11) : 2'b00;
  assign fl_ce_n   = (state_q == ST_IDLE);
  assign fl_we_n   = (state_q != ST_WLO);
  assign fl_oe_n   = (state_q != ST_RDLO);
  assign fl_byte_n = !byte_q;
  assign fl_unlock = boot_q && (state_q != ST_IDLE);
  assign fl_addr   = addr_q;

  assign req_ready    = (state_q == ST_IDLE);
  assign done         = (state_q == ST_FIN);
  assign done_status  = stat_q;
  assign done_timeout = to_q;
  assign done_err     = to_q || stat_q[5] || stat_q[4] || stat_q[3];

  // checker counter: length of the current write-enable low pulse
  logic [TW-1:0] we_lo_cnt;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)                                   we_lo_cnt <= '0;
    else if (fl_we_n)                             we_lo_cnt <= '0;
    else if (we_lo_cnt != {TW{1'b1}})             we_lo_cnt <= we_lo_cnt + 1'b1;
  end

  AST_NO_CONTEND: assert property (@(posedge clk) disable iff (!rst_q)
    !fl_oe_n |-> (fl_dq_oe == 2'b00)); // R6
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(fl_oe_n) |-> ($past(fl_dq_oe) == 2'b00)); // R6
  AST_WE_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(fl_we_n) |-> (we_lo_cnt >= TW'(LO_CYC))); // R4
  AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_q)
    done |=> !done); // R7
  AST_BUSY_ADDR: assert property (@(posedge clk) disable iff (!rst_q)
    !req_ready |=> $stable(fl_addr)); // R13
  AST_UNLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(fl_unlock) |-> fl_we_n); // R12

endmodule

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 20;
  localparam int LIMIT = 400;
  localparam int LO    = 5;   // ceil(50/10)
  localparam int HI    = 2;   // ceil(20/10)
  localparam int WC    = 9;   // ceil(90/10)
  localparam int WB    = 20;  // ceil(200/10)

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_erase = 1'b0, req_boot = 1'b0, req_byte = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_data = '0;
  logic          req_ready, done, done_err, done_timeout;
  logic [7:0]    done_status;
  logic          fl_ce_n, fl_we_n, fl_oe_n, fl_byte_n, fl_unlock;
  logic [AW-1:0] fl_addr;
  logic [15:0]   fl_dq_out, fl_dq_in;
  logic [1:0]    fl_dq_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq #(.AW(AW), .CLK_NS(CLK_PERIOD), .POLL_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_erase(req_erase), .req_boot(req_boot), .req_byte(req_byte),
    .req_addr(req_addr), .req_data(req_data), .done(done),
    .done_status(done_status), .done_err(done_err), .done_timeout(done_timeout),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_byte_n(fl_byte_n),
    .fl_unlock(fl_unlock), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
    .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in));

  int total = 0, bad = 0, cycles = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // device model
  logic [AW-1:0] wr_addr [0:7];
  logic [15:0]   wr_data [0:7];
  int            wr_cnt = 0;
  int            busy_left = 0;
  int            busy_set = 0;
  logic [7:0]    dev_stat = 8'h80;
  logic [7:0]    dev_now;
  assign dev_now  = (busy_left != 0) ? 8'h00 : dev_stat;
  assign fl_dq_in = (!fl_oe_n && !fl_ce_n) ? {8'h00, dev_now} : 16'h0000;

  // expectations of the running operation
  logic       e_boot = 1'b0, e_byte = 1'b0;
  int         done_cnt = 0;
  logic [7:0] got_stat = 8'h00;
  logic       got_err = 1'b0, got_to = 1'b0;

  logic          p_we = 1'b1, p_oe = 1'b1;
  logic [1:0]    p_dqoe = 2'b00;
  int            lo_cnt = 0, hi_cnt = 1000, last_lo = 0, gap = 0;
  bit            first_rd = 0;
  logic [AW-1:0] c_addr;
  logic [15:0]   c_data;

  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      if (!fl_we_n && p_we) begin
        chk(fl_unlock == e_boot, "R12", fl_unlock, e_boot);
        chk(fl_dq_oe == (e_byte ? 2'b01 : 2'b11), "R11", fl_dq_oe, e_byte ? 2'b01 : 2'b11);
        chk(fl_byte_n == !e_byte, "R11", fl_byte_n, !e_byte);
        if (hi_cnt < 100) begin
          chk(hi_cnt >= HI, "R4", hi_cnt, HI);
          chk(hi_cnt + last_lo >= WC, "R4", hi_cnt + last_lo, WC);
        end
        lo_cnt = 1; c_addr = fl_addr; c_data = fl_dq_out;
      end else if (!fl_we_n) begin
        lo_cnt++;
        if (fl_addr != c_addr || fl_dq_out != c_data)
          chk(0, "R4", fl_addr, c_addr);
      end else if (fl_we_n && !p_we) begin
        chk(lo_cnt >= LO, "R4", lo_cnt, LO);
        if (wr_cnt < 8) begin
          wr_addr[wr_cnt] = c_addr; wr_data[wr_cnt] = c_data;
        end
        wr_cnt++;
        if (wr_cnt == 2) busy_left = busy_set;
        last_lo = lo_cnt; hi_cnt = 1; gap = 1; first_rd = (wr_cnt == 2);
      end else begin
        hi_cnt++; gap++;
      end
      if (!fl_oe_n) begin
        if (fl_dq_oe != 2'b00) chk(0, "R6", fl_dq_oe, 0);
        if (p_oe && p_dqoe != 2'b00) chk(0, "R6", p_dqoe, 0);
        if (p_oe && first_rd) begin
          chk(gap - 1 >= WB, "R5", gap - 1, WB);
          first_rd = 0;
        end
      end
      if (done) begin
        done_cnt++; got_stat = done_status; got_err = done_err; got_to = done_timeout;
      end
      if (busy_left > 0) busy_left--;
      p_we = fl_we_n; p_oe = fl_oe_n; p_dqoe = fl_dq_oe;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic run_op(input bit erase, input bit boot, input bit bytem,
                        input logic [AW-1:0] a, input logic [15:0] d,
                        input int busy, input logic [2:0] errs, input bit poke);
    logic [7:0] exp_stat;
    logic [15:0] exp_d1;
    bit exp_to;
    exp_to   = (busy < 0);
    dev_stat = {2'b10, errs, 3'b000};
    busy_set = exp_to ? 32'h7fffffff : busy;
    exp_stat = exp_to ? 8'h00 : dev_stat;
    e_boot = boot; e_byte = bytem;
    wr_cnt = 0; done_cnt = 0;
    @(negedge clk);
    req_valid = 1; req_erase = erase; req_boot = boot; req_byte = bytem;
    req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      req_valid = 1; req_erase = !erase; req_addr = ~a; req_data = ~d;
      @(negedge clk);
      req_valid = 0;
    end
    while (!req_ready) @(negedge clk);
    chk(fl_unlock == 0, "R12", fl_unlock, 0);
    chk(wr_cnt == 4, poke ? "R13" : "R10", wr_cnt, 4);
    exp_d1 = erase ? 16'h00D0 : (bytem ? {8'h00, d[7:0]} : d);
    chk(wr_data[0] == (erase ? 16'h0020 : 16'h0040), erase ? "R3" : "R2", wr_data[0], erase ? 16'h20 : 16'h40);
    chk(wr_data[1] == exp_d1, erase ? "R3" : "R2", wr_data[1], exp_d1);
    chk(wr_addr[1] == a, poke ? "R13" : "R2", wr_addr[1], a);
    chk(wr_data[2] == 16'h0050, "R10", wr_data[2], 16'h50);
    chk(wr_data[3] == 16'h00FF, "R10", wr_data[3], 16'hFF);
    chk(done_cnt == 1, "R7", done_cnt, 1);
    chk(got_stat == exp_stat, "R7", got_stat, exp_stat);
    chk(got_to == exp_to, "R9", got_to, exp_to);
    chk(got_err == (exp_to || (errs != 0)), "R8", got_err, exp_to || (errs != 0));
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    #(3*CLK_PERIOD);
    @(negedge clk);
    chk(fl_ce_n && fl_we_n && fl_oe_n, "R1", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
    chk(fl_dq_oe == 0 && fl_unlock == 0 && done == 0, "R1", {fl_dq_oe, fl_unlock, done}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && fl_we_n == 1 && fl_dq_oe == 0, "R1", {req_ready, fl_we_n, fl_dq_oe}, 4'b1100);
    // directed corners
    run_op(0, 0, 0, 20'h12345, 16'hBEEF, 0,  3'b000, 0);  // R2 word, ready at once
    run_op(0, 0, 1, 20'h00010, 16'hA55A, 7,  3'b000, 0);  // R11 byte program
    run_op(1, 1, 0, 20'hF0000, 16'h0000, 90, 3'b100, 0);  // R3 R12 R8 erase error
    run_op(0, 1, 1, 20'h00003, 16'h1234, 15, 3'b011, 0);  // R8 prog+vpp
    run_op(1, 0, 0, 20'h40000, 16'h0000, -1, 3'b000, 0);  // R9 timeout
    run_op(0, 0, 0, 20'h0ABCD, 16'h5678, 30, 3'b000, 1);  // R13 poke while busy
    // constrained random
    for (int i = 0; i < 14; i++) begin
      run_op($urandom_range(1), $urandom_range(1), $urandom_range(1),
             AW'($urandom), 16'($urandom), $urandom_range(60),
             ($urandom_range(3) == 0) ? 3'($urandom) : 3'b000, 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule